// File: doc/BRIEF.md
# Byte-Merging Read Forwarder for a Cache Data Path

This block sits on the data-output side of a cache whose row storage cannot show a write to a read until two cycles later. Each row is 64 bits, or eight byte lanes. One write port carries either a store, which updates only the lanes its mask enables, or a refill row from the memory bus, which updates all eight lanes. One read port requests a row by index. A write passes through two forwarding stages before the storage array holds it. The newest pending write is the one being committed to the array in the current cycle. The one before it sits in a second-stage register.

In the cycle after a read request, the stored row comes back. Each output byte is then chosen on its own from four places: the array read data, a refill row arriving on the write port in that cycle, the write being committed this cycle, or the second-stage register. A source is used only if its row index matches the row being read. The merged row is captured in an output register. Two partial stores to different lanes of one row, issued back to back, therefore both show up in a read that follows them.

Top module: `row_fwd_merge`

## Requirements
- R1: While rstN is low and after reset, outValid is 0 and dataOut is 0 until the first read result.
- R2: A read requested with rdEn high in cycle r raises outValid in cycle r+2, and only then. outValid is never high without such a request.
- R3: A read returns the row as left by every write presented before the read request.
- R4: A store with wrRefill=0 changes only the lanes whose wrMask bit is set. Mask bit b covers data bits [8b+7:8b]. The other lanes keep their earlier contents.
- R5: A write presented in the same cycle as a read request to the same row is visible in that read's result.
- R6: A write presented one cycle before a read request to the same row is visible in that read's result.
- R7: Two stores to disjoint lanes of one row, in consecutive cycles, are both visible in a later read of that row, including a read issued together with the second store.
- R8: When two pending writes cover the same lane of the row being read, the later write supplies that lane.
- R9: A write with wrRefill=1 writes all eight lanes and ignores wrMask. A refill to the read row, presented in the cycle after the read request, supplies every byte of that read's result.
- R10: A store with wrRefill=0 presented in the cycle after a read request does not affect that read's result.
- R11: A write to a row other than the one being read never changes the read result.
- R12: dataOut holds its value in every cycle that outValid is low.
- R13: When wrEn is low, wrData, wrMask and wrRefill change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read request strobe |
| rdRow | input | ROW_AW | Row index to read |
| wrEn | input | 1 | Write strobe |
| wrRefill | input | 1 | 1: refill row from the bus, all lanes; 0: masked store |
| wrRow | input | ROW_AW | Row index to write |
| wrData | input | 64 | Write data, lane b in bits [8b+7:8b] |
| wrMask | input | 8 | Store lane enables, bit b for lane b |
| dataOut | output | 64 | Registered merged read row |
| outValid | output | 1 | dataOut holds a new read result |

## Verification
A read requested in cycle r has its result registered at the end of cycle r+1, so outValid and dataOut for that read are due in cycle r+2. The bench samples on the falling edge. It keeps each expected row in a two-deep queue that advances once per cycle, so every comparison lands exactly two cycles after its request. The expected row is built from a byte-level model after applying all writes up to and including the request cycle. It is then patched by a refill seen in the next cycle, because a refill in the mux cycle is the only later write that may reach the result. A store in that cycle is left out of the expected row, and in idle cycles dataOut is compared with the last result delivered.

// File: rtl/rowfwd_pkg.sv
package rowfwd_pkg;

  localparam int ROW_BYTES = 8;
  localparam int ROW_BITS  = ROW_BYTES * 8;

  // Per-lane source chosen for the output register
  typedef enum logic [1:0] {
    SRC_RAM = 2'd0,  // array read data
    SRC_BUS = 2'd1,  // refill row on the write port this cycle
    SRC_CUR = 2'd2,  // write being committed to the array this cycle
    SRC_OLD = 2'd3   // second-stage forwarding register
  } byteSrc_e;

  typedef struct packed {
    logic                         ramWe;
    logic                         outLoad;
    byteSrc_e [ROW_BYTES-1:0]     sel;
  } ctlStrobe_t;

endpackage

// File: rtl/rowfwd_ctrl.sv
module rowfwd_ctrl
  import rowfwd_pkg::*;
#(
  parameter int ROW_AW = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic [ROW_AW-1:0]    rdRow,
  input  logic                 wrEn,
  input  logic                 wrRefill,
  input  logic [ROW_AW-1:0]    wrRow,
  input  logic [ROW_BYTES-1:0] wrMask,
  output ctlStrobe_t           strobe,
  output logic [ROW_AW-1:0]    commitRow,
  output logic [ROW_BYTES-1:0] commitMask
);

  logic                 rdQv;
  logic [ROW_AW-1:0]    rdRowQ;
  logic                 s1Valid, s2Valid;
  logic [ROW_AW-1:0]    s1Row, s2Row;
  logic [ROW_BYTES-1:0] s1Mask, s2Mask;
  logic [ROW_BYTES-1:0] effMask;
  logic                 busHit, s1Hit, s2Hit;

  assign effMask = wrRefill ? {ROW_BYTES{1'b1}} : wrMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQv    <= 1'b0;
      rdRowQ  <= '0;
      s1Valid <= 1'b0;
      s1Row   <= '0;
      s1Mask  <= '0;
      s2Valid <= 1'b0;
      s2Row   <= '0;
      s2Mask  <= '0;
    end else begin
      rdQv    <= rdEn;
      rdRowQ  <= rdRow;
      s1Valid <= wrEn;
      s1Row   <= wrRow;
      s1Mask  <= effMask;
      s2Valid <= s1Valid;
      s2Row   <= s1Row;
      s2Mask  <= s1Mask;
    end
  end

  // Forwarding decision uses row-index comparison only
  assign busHit = rdQv && wrEn && wrRefill && (wrRow == rdRowQ);
  assign s1Hit  = s1Valid && (s1Row == rdRowQ);
  assign s2Hit  = s2Valid && (s2Row == rdRowQ);

  always_comb begin
    strobe.ramWe   = s1Valid;
    strobe.outLoad = rdQv;
    for (int b = 0; b < ROW_BYTES; b++) begin
      if (busHit)                    strobe.sel[b] = SRC_BUS;
      else if (s1Hit && s1Mask[b])   strobe.sel[b] = SRC_CUR;
      else if (s2Hit && s2Mask[b])   strobe.sel[b] = SRC_OLD;
      else                           strobe.sel[b] = SRC_RAM;
    end
  end

  assign commitRow  = s1Row;
  assign commitMask = s1Mask;

endmodule

// File: rtl/rowfwd_dp.sv
module rowfwd_dp
  import rowfwd_pkg::*;
#(
  parameter int ROW_AW = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [ROW_AW-1:0]    commitRow,
  input  logic [ROW_BYTES-1:0] commitMask,
  input  logic                 rdEn,
  input  logic [ROW_AW-1:0]    rdRow,
  input  logic [ROW_BITS-1:0]  wrData,
  output logic [ROW_BITS-1:0]  dataOut,
  output logic                 outValid
);

  localparam int ROWS = 1 << ROW_AW;

  logic [ROW_BITS-1:0] rowMem [ROWS];
  logic [ROW_BITS-1:0] s1Data, s2Data, ramRd, mergeRow;

  // Staged write data; stage 1 is committed to the array
  always_ff @(posedge clk) begin
    s1Data <= wrData;
    s2Data <= s1Data;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < ROW_BYTES; b++) begin
      if (strobe.ramWe && commitMask[b])
        rowMem[commitRow][b*8 +: 8] <= s1Data[b*8 +: 8];
    end
  end

  // Read-before-write: a commit at the same edge is not seen
  always_ff @(posedge clk) begin
    if (rdEn) ramRd <= rowMem[rdRow];
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
    always_comb begin
      unique case (strobe.sel[g])
        SRC_BUS: mergeRow[g*8 +: 8] = wrData[g*8 +: 8];
        SRC_CUR: mergeRow[g*8 +: 8] = s1Data[g*8 +: 8];
        SRC_OLD: mergeRow[g*8 +: 8] = s2Data[g*8 +: 8];
        default: mergeRow[g*8 +: 8] = ramRd[g*8 +: 8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.outLoad;
      if (strobe.outLoad) dataOut <= mergeRow;
    end
  end

  // R12
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(dataOut));

endmodule

// File: rtl/row_fwd_merge.sv
module row_fwd_merge
  import rowfwd_pkg::*;
#(
  parameter int ROW_AW = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic [ROW_AW-1:0]    rdRow,
  input  logic                 wrEn,
  input  logic                 wrRefill,
  input  logic [ROW_AW-1:0]    wrRow,
  input  logic [ROW_BITS-1:0]  wrData,
  input  logic [ROW_BYTES-1:0] wrMask,
  output logic [ROW_BITS-1:0]  dataOut,
  output logic                 outValid
);

  ctlStrobe_t           strobe;
  logic [ROW_AW-1:0]    commitRow;
  logic [ROW_BYTES-1:0] commitMask;

  rowfwd_ctrl #(.ROW_AW(ROW_AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdEn       (rdEn),
    .rdRow      (rdRow),
    .wrEn       (wrEn),
    .wrRefill   (wrRefill),
    .wrRow      (wrRow),
    .wrMask     (wrMask),
    .strobe     (strobe),
    .commitRow  (commitRow),
    .commitMask (commitMask)
  );

  rowfwd_dp #(.ROW_AW(ROW_AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .commitRow  (commitRow),
    .commitMask (commitMask),
    .rdEn       (rdEn),
    .rdRow      (rdRow),
    .wrData     (wrData),
    .dataOut    (dataOut),
    .outValid   (outValid)
  );

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> ##2 outValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rdEn, 2));

  // R9
  refill_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdEn, 2) && $past(wrEn) && $past(wrRefill) &&
     ($past(wrRow) == $past(rdRow, 2))) |-> (dataOut == $past(wrData)));

endmodule

// File: tb/row_fwd_merge_bench.sv
`timescale 1ns/1ps
module row_fwd_merge_bench;

  localparam int AW = 5;
  localparam int NROWS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          rdEn;
  logic [AW-1:0] rdRow;
  logic          wrEn;
  logic          wrRefill;
  logic [AW-1:0] wrRow;
  logic [63:0]   wrData;
  logic [7:0]    wrMask;
  logic [63:0]   dataOut;
  logic          outValid;

  always #2.5 clk = ~clk;

  row_fwd_merge #(.ROW_AW(AW)) u_row_fwd_merge (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdRow(rdRow), .wrEn(wrEn),
    .wrRefill(wrRefill), .wrRow(wrRow), .wrData(wrData), .wrMask(wrMask),
    .dataOut(dataOut), .outValid(outValid)
  );

  int unsigned vecCnt = 0;
  int unsigned errCnt = 0;
  bit          done = 0;

  logic [63:0] refMem [NROWS];
  logic          p1v = 0, p2v = 0;
  logic [AW-1:0] p1row = '0;
  logic [63:0]   p1d = '0, p2d = '0, lastOut = '0;
  string         p1tag = "", p2tag = "";

  function automatic logic [63:0] mergeBytes(logic [63:0] oldv, logic [63:0] newv,
                                             logic [7:0] m);
    logic [63:0] r = oldv;
    for (int b = 0; b < 8; b++) if (m[b]) r[b*8 +: 8] = newv[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: check outputs due now, drive inputs, update model
  task automatic cyc(input logic re, input logic [AW-1:0] rr, input logic we,
                     input logic rf, input logic [AW-1:0] wr, input logic [63:0] wd,
                     input logic [7:0] wm, input string tag);
    if (p2v) begin
      check(outValid === 1'b1, "R2", {63'd0, outValid}, 64'd1);
      check(dataOut === p2d, p2tag, dataOut, p2d);
      lastOut = p2d;
    end else begin
      check(outValid === 1'b0, "R2", {63'd0, outValid}, 64'd0);
      check(dataOut === lastOut, "R12", dataOut, lastOut);
    end
    rdEn = re; rdRow = rr; wrEn = we; wrRefill = rf; wrRow = wr;
    wrData = wd; wrMask = wm;
    if (p1v && we && rf && wr == p1row) p1d = wd;
    if (we) refMem[wr] = mergeBytes(refMem[wr], wd, rf ? 8'hFF : wm);
    p2v = p1v; p2d = p1d; p2tag = p1tag;
    p1v = re; p1row = rr; p1d = refMem[rr]; p1tag = tag;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, '0, '0, '0, "R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; rdEn = 0; rdRow = '0; wrEn = 0; wrRefill = 0; wrRow = '0;
    wrData = '0; wrMask = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(outValid === 1'b0, "R1", {63'd0, outValid}, 64'd0);
    check(dataOut === 64'd0, "R1", dataOut, 64'd0);
    rstN = 1;
    @(negedge clk);
    // R1 after release
    check(outValid === 1'b0 && dataOut === 64'd0, "R1", dataOut, 64'd0);

    // preload every row with full-mask stores
    for (int r = 0; r < NROWS; r++)
      cyc(0, '0, 1, 0, AW'(r), {32'hA5A5_0000 | r, 32'h1111_0000 | r}, 8'hFF, "R12");
    idle(3);

    // R3 plain read of a settled row
    cyc(1, 5'd3, 0, 0, '0, '0, '0, "R3");
    idle(2);
    // R4 partial store then read after it settles
    cyc(0, '0, 1, 0, 5'd4, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F, "R12");
    idle(3);
    cyc(1, 5'd4, 0, 0, '0, '0, '0, "R4");
    idle(2);
    // R5 write and read in the same cycle
    cyc(1, 5'd5, 1, 0, 5'd5, 64'h0102_0304_0506_0708, 8'hF0, "R5");
    idle(2);
    // R6 write one cycle ahead of the read
    cyc(0, '0, 1, 0, 5'd6, 64'h99AA_BBCC_DDEE_FF00, 8'h3C, "R12");
    cyc(1, 5'd6, 0, 0, '0, '0, '0, "R6");
    idle(2);
    // R7 two disjoint partial stores, read with the second
    cyc(0, '0, 1, 0, 5'd7, 64'h1111_1111_1111_1111, 8'h03, "R12");
    cyc(1, 5'd7, 1, 0, 5'd7, 64'h2222_2222_2222_2222, 8'h30, "R7");
    idle(2);
    // R7 same pair, read one cycle later
    cyc(0, '0, 1, 0, 5'd17, 64'h3333_3333_3333_3333, 8'h81, "R12");
    cyc(0, '0, 1, 0, 5'd17, 64'h4444_4444_4444_4444, 8'h18, "R12");
    cyc(1, 5'd17, 0, 0, '0, '0, '0, "R7");
    idle(2);
    // R8 overlapping lanes, later store wins
    cyc(0, '0, 1, 0, 5'd8, 64'hAAAA_AAAA_AAAA_AAAA, 8'hFF, "R12");
    cyc(1, 5'd8, 1, 0, 5'd8, 64'hBBBB_BBBB_BBBB_BBBB, 8'h0F, "R8");
    idle(2);
    // R9 refill in the cycle after the read, mask ignored
    cyc(1, 5'd9, 0, 0, '0, '0, '0, "R9");
    cyc(0, '0, 1, 1, 5'd9, 64'h7777_6666_5555_4444, 8'h01, "R12");
    idle(3);
    cyc(1, 5'd9, 0, 0, '0, '0, '0, "R9");
    idle(2);
    // R10 store in the cycle after the read is not seen
    cyc(1, 5'd10, 0, 0, '0, '0, '0, "R10");
    cyc(0, '0, 1, 0, 5'd10, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R12");
    idle(3);
    // R11 write to another row in the read cycle
    cyc(1, 5'd12, 1, 0, 5'd11, 64'h5A5A_5A5A_5A5A_5A5A, 8'hFF, "R11");
    cyc(0, '0, 1, 1, 5'd11, 64'h6B6B_6B6B_6B6B_6B6B, 8'hFF, "R12");
    idle(2);
    // R13 disabled write carries data and mask
    cyc(0, '0, 0, 1, 5'd13, 64'h0BAD_0BAD_0BAD_0BAD, 8'hFF, "R12");
    cyc(1, 5'd13, 0, 0, 5'd13, 64'h0BAD_0BAD_0BAD_0BAD, 8'hFF, "R13");
    idle(3);
    cyc(1, 5'd13, 0, 0, '0, '0, '0, "R13");
    idle(2);

    // random traffic over a few rows to force collisions
    for (int i = 0; i < 4000; i++) begin
      logic          re, we, rf;
      logic [AW-1:0] rr, wr;
      logic [63:0]   wd;
      logic [7:0]    wm;
      re = ($urandom % 10) < 6;
      we = ($urandom % 2) == 1;
      rf = ($urandom % 5) == 0;
      rr = AW'($urandom % 4);
      wr = AW'($urandom % 4);
      wd = {$urandom, $urandom};
      wm = 8'($urandom);
      cyc(re, rr, we, rf, wr, wd, wm, "R8");
    end
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule